// File: doc/BRIEF.md
# Sequence-Match Hardware Checker

This block is a synthesizable property monitor. It watches a small vector of sampled boolean signals and raises a one-bit flag when the signals trace out a fixed temporal sequence. The sequence is compiled by hand into a state graph. Each graph state holds one flip-flop, and every edge between states carries a guard: the AND of some input bits. A state bit is set on the next clock when any active source state has an edge into it whose guard holds. Because the repetition terms make the graph nondeterministic, several state bits can be set at once, and every partial match advances in parallel.

The recognised sequence is built from two operands. The left operand is `a` followed by zero or more cycles of `b`. The right operand is zero or more cycles of `c` followed by `d`. The two operands are fused, so the left operand's last cycle is also the right operand's first cycle. After the fused part comes `e`. With t0 as the first clock edge after reset, the sequence matches when there are counts j ≥ 0 and k ≥ 0 such that:

- `a` holds at t0,
- `b` holds at t0+1 … t0+j,
- `c` holds at t0+j … t0+j+k-1,
- `d` holds at t0+j+k,
- `e` holds at t0+j+k+1.

Only one attempt is made, starting at t0. The block is placed beside a design in a prototyping fabric so that a property violation or event can be seen in hardware.

Top module: `seq_match_checker`

## Requirements
- R1: Input `din` bit positions are: 0 = constant true (tie high), 1 = a, 2 = b, 3 = c, 4 = d, 5 = e.
- R2: Reset is synchronous and active high. It leaves only the initial state set. `match_o` is 0 in every cycle where `rst` is high, even if the accepting state bit is still set.
- R3: When `a` and `d` both hold at t0 and `e` holds at t0+1, `match_o` is 1 after the edge that samples `e`.
- R4: The `b` run may have any length, including zero. The match completes at the cycle given by the formula above, with j equal to the run length.
- R5: Fusion: the cycle that ends the `a`/`b` part must also satisfy the first element of the right operand (`c`, or `d` when k = 0). A lone `a` followed directly by `d` in the next cycle does not match.
- R6: The `c` run may have any length, including zero, and may start in the same cycle as `a`.
- R7: Concatenation: `e` must hold in the cycle right after `d`. A cycle with neither gives no match.
- R8: Only the attempt starting at t0 is tracked. An `a` first seen in a later cycle never produces a match.
- R9: Bit 0 is ANDed into every edge guard. If it is low in any cycle a path consumes, that path dies.
- R10: When several (j, k) paths complete in different cycles, `match_o` pulses once in each of those cycles, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; also masks `match_o` |
| din | input | IN_W (6) | Sampled booleans: bit0 true, bits 1..5 = a, b, c, d, e |
| match_o | output | 1 | Accepting-state flag gated by reset |

## Verification
The bench focuses on three areas.

- **Fusion cycle.** A checker that chained the two operands instead of fusing them would either miss a pattern such as `a` with `d` in the same cycle, or accept `a` followed by `d` one cycle later.
- **Zero-length repetitions and overlapping paths.** A single trace can hold several live paths. A design that kept only one path, or that lacked the skip edges, would drop some completion pulses or place them a cycle late.
- **Reset masking, late starts and a cleared constant-true bit.** An ungated output would show a stale match during reset. A design that re-armed the initial state would accept a late `a`.

// File: rtl/seqchk_pkg.sv
package seqchk_pkg;

  localparam int IN_W   = 6;
  localparam int ST_N   = 5;
  localparam int EDGE_N = 9;
  localparam int ST_W   = $clog2(ST_N);

  // input bit positions
  localparam int B_TRUE = 0;
  localparam int B_A    = 1;
  localparam int B_B    = 2;
  localparam int B_C    = 3;
  localparam int B_D    = 4;
  localparam int B_E    = 5;

  // state indices: 0 start, 1 left running, 2 right in c run, 3 need e, 4 accept
  localparam int S_START = 0;
  localparam int S_LEFT  = 1;
  localparam int S_CRUN  = 2;
  localparam int S_NEEDE = 3;
  localparam int S_ACC   = ST_N - 1;

  typedef struct packed {
    logic [ST_W-1:0] src;
    logic [ST_W-1:0] dst;
    logic [IN_W-1:0] need;
  } arc_t;

  function automatic logic [IN_W-1:0] bitm(input int pos);
    logic [IN_W-1:0] m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction

  function automatic arc_t mk_arc(input int s, input int d, input logic [IN_W-1:0] need);
    arc_t r;
    r.src  = ST_W'(s);
    r.dst  = ST_W'(d);
    r.need = need | bitm(B_TRUE);
    return r;
  endfunction

  // edge list: every guard is ANDed with the constant-true bit
  function automatic arc_t arc_at(input int idx);
    arc_t r;
    case (idx)
      0:       r = mk_arc(S_START, S_LEFT,  bitm(B_A));
      1:       r = mk_arc(S_START, S_CRUN,  bitm(B_A) | bitm(B_C));
      2:       r = mk_arc(S_START, S_NEEDE, bitm(B_A) | bitm(B_D));
      3:       r = mk_arc(S_LEFT,  S_LEFT,  bitm(B_B));
      4:       r = mk_arc(S_LEFT,  S_CRUN,  bitm(B_B) | bitm(B_C));
      5:       r = mk_arc(S_LEFT,  S_NEEDE, bitm(B_B) | bitm(B_D));
      6:       r = mk_arc(S_CRUN,  S_CRUN,  bitm(B_C));
      7:       r = mk_arc(S_CRUN,  S_NEEDE, bitm(B_D));
      default: r = mk_arc(S_NEEDE, S_ACC,   bitm(B_E));
    endcase
    return r;
  endfunction

endpackage

// File: rtl/seqchk_guard.sv
module seqchk_guard
  import seqchk_pkg::*;
#(
  parameter int NIN   = IN_W,
  parameter int NEDGE = EDGE_N
) (
  input  logic [NIN-1:0]   din,
  output logic [NEDGE-1:0] hit
);
  for (genvar g = 0; g < NEDGE; g++) begin : g_arc
    localparam arc_t ARC = arc_at(g);
    assign hit[g] = &(din | ~ARC.need);
  end
endmodule

// File: rtl/seqchk_fire.sv
module seqchk_fire
  import seqchk_pkg::*;
#(
  parameter int NST   = ST_N,
  parameter int NEDGE = EDGE_N
) (
  input  logic [NST-1:0]   state,
  input  logic [NEDGE-1:0] hit,
  output logic [NEDGE-1:0] fire
);
  for (genvar g = 0; g < NEDGE; g++) begin : g_arc
    localparam arc_t ARC = arc_at(g);
    assign fire[g] = hit[g] & state[ARC.src];
  end
endmodule

// File: rtl/seqchk_next.sv
module seqchk_next
  import seqchk_pkg::*;
#(
  parameter int NST   = ST_N,
  parameter int NEDGE = EDGE_N
) (
  input  logic [NEDGE-1:0] fire,
  output logic [NST-1:0]   nxt
);
  for (genvar s = 0; s < NST; s++) begin : g_st
    always_comb begin
      nxt[s] = 1'b0;
      for (int e = 0; e < NEDGE; e++) begin
        if (arc_at(e).dst == ST_W'(s)) nxt[s] = nxt[s] | fire[e];
      end
    end
  end
endmodule

// File: rtl/seqchk_state.sv
module seqchk_state #(
  parameter int NST = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NST-1:0] nxt,
  output logic [NST-1:0] state_q
);
  localparam logic [NST-1:0] INIT_VEC = NST'(1);

  always_ff @(posedge clk) begin
    if (rst) state_q <= INIT_VEC;
    else     state_q <= nxt;
  end
endmodule

// File: rtl/seq_match_checker.sv
module seq_match_checker
  import seqchk_pkg::*;
#(
  parameter int NIN   = IN_W,
  parameter int NST   = ST_N,
  parameter int NEDGE = EDGE_N
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NIN-1:0] din,
  output logic           match_o
);
  logic [NEDGE-1:0] hit;
  logic [NEDGE-1:0] fire;
  logic [NST-1:0]   nxt;
  logic [NST-1:0]   state_q;

  seqchk_guard #(.NIN(NIN), .NEDGE(NEDGE)) u_guard (.din(din), .hit(hit));
  seqchk_fire  #(.NST(NST), .NEDGE(NEDGE)) u_fire  (.state(state_q), .hit(hit), .fire(fire));
  seqchk_next  #(.NST(NST), .NEDGE(NEDGE)) u_next  (.fire(fire), .nxt(nxt));
  seqchk_state #(.NST(NST))                u_state (.clk(clk), .rst(rst), .nxt(nxt), .state_q(state_q));

  // accepting state is the top bit; masked while reset is high
  assign match_o = state_q[NST-1] & ~rst;
endmodule

// File: rtl/seqchk_props.sv
module seqchk_props #(
  parameter int NIN = 6,
  parameter int NST = 5
) (
  input logic           clk,
  input logic           rst,
  input logic [NIN-1:0] din,
  input logic [NST-1:0] state_q,
  input logic           match_o
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  // R2
  always @(posedge clk) begin
    if (rst) begin
      rst_mask_chk: assert (!match_o);
    end
  end

  // R7
  e_before_match_chk: assert property (@(posedge clk) disable iff (rst)
    match_o |-> ($past(din[5]) && $past(din[0])));

  // R7
  d_two_back_chk: assert property (@(posedge clk) disable iff (rst)
    match_o |-> $past(din[4], 2));

  // R8
  single_start_chk: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> !state_q[0]);

  // R9
  true_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !$past(din[0])) |-> (state_q == '0));
endmodule

bind seq_match_checker seqchk_props #(.NIN(NIN), .NST(NST)) u_props (
  .clk(clk), .rst(rst), .din(din), .state_q(state_q), .match_o(match_o)
);

// File: tb/tb_seq_match_checker.sv
`timescale 1ns/1ps
module tb_seq_match_checker;
  localparam logic [5:0] T = 6'd1, A = 6'd2, B = 6'd4, C = 6'd8, D = 6'd16, E = 6'd32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] din = '0;
  logic       match_o;

  int checks = 0;
  int errors = 0;

  logic [5:0] cur[$];
  bit         expq[$];
  string      tagq[$];
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  seq_match_checker dut (.clk(clk), .rst(rst), .din(din), .match_o(match_o));

  // reference: does a path complete exactly at edge n of the attempt?
  function automatic bit expect_at(int n);
    for (int j = 0; j < n; j++) begin
      int  k;
      bit  ok;
      k  = n - 1 - j;
      ok = cur[0][1];
      for (int i = 0; i <= n; i++) if (!cur[i][0]) ok = 0;
      for (int i = 1; i <= j; i++) if (!cur[i][2]) ok = 0;
      for (int i = j; i < j + k; i++) if (!cur[i][3]) ok = 0;
      if (!cur[j + k][4]) ok = 0;
      if (!cur[n][5]) ok = 0;
      if (ok) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: match_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: reset, then one vector per edge, pushing the expected output
  task automatic run_trace(string tag);
    @(negedge clk);
    rst = 1'b1;
    din = '0;
    #1 check("R2 gated during reset", match_o, 1'b0);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R2 reset state", match_o, 1'b0);
    for (int n = 0; n < cur.size(); n++) begin
      rst = 1'b0;
      din = cur[n];
      expq.push_back(expect_at(n));
      tagq.push_back(tag);
      @(negedge clk);
    end
    din = '0;
    @(negedge clk);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) check(tagq.pop_front(), match_o, expq.pop_front());
    end
  end

  initial begin
    cur = '{T|A|D, T|E, T};                      run_trace("R3 direct a&d then e (R1)");
    cur = '{T|A, T|B, T|B|D, T|E, T};            run_trace("R4 b run of two");
    cur = '{T|A|D, T|B, T|E};                    run_trace("R4 zero b with extra b");
    cur = '{T|A, T|D, T|E};                      run_trace("R5 no fusion cycle");
    cur = '{T|A, T|B|C, T|C, T|D, T|E};          run_trace("R6 c run fused with b");
    cur = '{T|A|C, T|C, T|D, T|E};               run_trace("R6 c starts with a");
    cur = '{T|A|D, T|D, T|E};                    run_trace("R7 gap after d");
    cur = '{T|A, T|B, T, T|D, T|E};              run_trace("R7 broken b run");
    cur = '{T, T|A|D, T|E, T|A|D, T|E};          run_trace("R8 late start");
    cur = '{A|D, T|E};                           run_trace("R9 true bit low at t0");
    cur = '{T|A|D, E};                           run_trace("R9 true bit low at e");
    cur = '{T|A|C|D, T|B|C|D|E, T|C|D|E, T|E, T}; run_trace("R10 overlapping paths");
    cur = '{T|A|B|C|D, T|B|C|D|E, T|B|C|D|E, T|B|C|D|E, T|E}; run_trace("R10 pulse every cycle");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule